// File: doc/BRIEF.md
# Grouped Priority DMA Channel Allocator

This block hands out physical DMA channels, up to 32 of them. Each channel has a busy flag. When a client asks for a channel, the allocator grants the free channel that ranks best. Rank is set first by the channel's priority group and then by its index. The granted channel is marked busy. A separate release port frees a channel by number. An allocation and a release may arrive in the same cycle.

The block also keeps a routing table from peripheral request lines to channels. A grant records its channel, marked valid, in the table entry of the request line named with the allocation. When that line's request is asserted, it is steered onto the channel it maps to. A release wipes every table entry that points at the freed channel. Software can read any table entry through a read port.

Top module: `dma_chan_alloc`

## Requirements
- R1: After reset, all channels are free, every map entry reads zero, and `alloc_ok`, `alloc_none`, `alloc_chan` and `chan_req` are all zero.
- R2: The priority group of channel i is (i mod 16)/4, and group 0 ranks highest. A grant picks the free channel in the best group, and within that group the lowest index.
- R3: A grant is reported one clock after `alloc_req`: `alloc_ok` is high for one cycle and `alloc_chan` holds the channel number. From that same clock, the channel's bit in `chan_busy` is set. No other busy bit ever becomes set.
- R4: If no eligible channel is free, `alloc_none` pulses one clock after the request. In that case `alloc_ok` stays low, `chan_busy` is unchanged and no map entry is written.
- R5: A release of channel c, where c is below N_CH, clears busy bit c one clock later. The same clock clears to zero every map entry that is valid and holds channel c. A release of a channel number at or above N_CH has no effect.
- R6: When a release and an allocation arrive in the same cycle, the release is applied first. The channel just released can therefore be granted by that same allocation.
- R7: On a grant, the entry for `alloc_line` becomes valid and holds the granted channel. From then on, `per_req[alloc_line]` drives `chan_req[channel]` combinationally.
- R8: A request on a line whose map entry is not valid has no effect: no bit of `chan_req` is driven by it.
- R9: When N_CH is below 32, only groups 0 up to ((N_CH-1) mod 16)/4 are searched. Channels in higher groups are never granted.
- R10: A map entry reads as an 8-bit value with the valid bit at bit 7, the channel number in bits 4..0, and bits 6..5 always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one channel this cycle |
| alloc_line | input | LW | Peripheral line to bind to the granted channel |
| rel_en | input | 1 | Release a channel this cycle |
| rel_chan | input | 5 | Channel to release |
| per_req | input | N_LINES | Peripheral request lines |
| map_rd_line | input | LW | Map entry selected for reading |
| map_rd_data | output | 8 | Selected map entry (valid at bit 7, channel at bits 4..0) |
| chan_req | output | N_CH | Requests routed to channels |
| chan_busy | output | N_CH | Busy flag of each channel |
| alloc_ok | output | 1 | Grant pulse |
| alloc_none | output | 1 | No-channel pulse |
| alloc_chan | output | 5 | Granted channel number |

## Verification
The bench first fills every channel with a run of back-to-back allocations. The grant order that results, 0..3, 16..19, 4..7 and so on, can only come from the grouped ranking: a plain lowest-index search would give a different order. A second instance with 20 channels gets the same stimulus. It must report no channel after eight grants, although channels 4..15 are still free, which shows the search is limited to the groups that exist. Single releases, releases in the same cycle as an allocation, and releases of out-of-range numbers show that release is applied first and that map entries are wiped by channel. A long random phase, compared against a reference model on every clock, covers mixed traffic together with routing through valid and invalid map entries.

// File: rtl/dca_pkg.sv
`timescale 1ns/1ps
package dca_pkg;
  localparam int CHW = 5;

  // priority group of a channel index; 0 is the best
  function automatic int prio_level(input int idx);
    return (idx % 16) / 4;
  endfunction

  // last group that the search visits for a given channel count
  function automatic int top_level(input int n);
    return ((n - 1) % 16) / 4;
  endfunction

  function automatic logic [7:0] map_entry(input logic v, input logic [CHW-1:0] c);
    return {v, 2'b00, c};
  endfunction
endpackage

// File: rtl/dca_pick.sv
`timescale 1ns/1ps
module dca_pick #(
  parameter int N_CH = 32
) (
  input  logic [N_CH-1:0]         free,
  output logic                    found,
  output logic [dca_pkg::CHW-1:0] idx
);
  import dca_pkg::*;
  localparam int TOP = top_level(N_CH);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int lv = 0; lv < 4; lv++) begin
      if (lv <= TOP) begin
        for (int i = 0; i < N_CH; i++) begin
          if (!found && prio_level(i) == lv && free[i]) begin
            found = 1'b1;
            idx   = CHW'(i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dca_map.sv
`timescale 1ns/1ps
module dca_map #(
  parameter int N_CH    = 32,
  parameter int N_LINES = 16,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [LW-1:0]           wr_line,
  input  logic [dca_pkg::CHW-1:0] wr_chan,
  input  logic                    clr_en,
  input  logic [dca_pkg::CHW-1:0] clr_chan,
  input  logic [LW-1:0]           rd_line,
  input  logic [N_LINES-1:0]      per_req,
  output logic [7:0]              rd_data,
  output logic [N_CH-1:0]         chan_req
);
  import dca_pkg::*;

  logic [N_LINES-1:0]          line_v;
  logic [N_LINES-1:0][CHW-1:0] line_c;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic           v_q;
    logic [CHW-1:0] c_q;
    logic           hit_wr, hit_clr;
    assign hit_wr  = wr_en && (wr_line == LW'(l));
    assign hit_clr = clr_en && v_q && (c_q == clr_chan);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else if (hit_wr) begin
        v_q <= 1'b1;
        c_q <= wr_chan;
      end else if (hit_clr) begin
        v_q <= 1'b0;
        c_q <= '0;
      end
    end
    assign line_v[l] = v_q;
    assign line_c[l] = c_q;
  end

  always_comb begin
    chan_req = '0;
    for (int l = 0; l < N_LINES; l++) begin
      for (int c = 0; c < N_CH; c++) begin
        if (per_req[l] && line_v[l] && line_c[l] == CHW'(c)) chan_req[c] = 1'b1;
      end
    end
  end

  assign rd_data = map_entry(line_v[rd_line], line_c[rd_line]);
endmodule

// File: rtl/dma_chan_alloc.sv
`timescale 1ns/1ps
module dma_chan_alloc #(
  parameter int N_CH    = 32,
  parameter int N_LINES = 16,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_req,
  input  logic [LW-1:0]      alloc_line,
  input  logic               rel_en,
  input  logic [4:0]         rel_chan,
  input  logic [N_LINES-1:0] per_req,
  input  logic [LW-1:0]      map_rd_line,
  output logic [7:0]         map_rd_data,
  output logic [N_CH-1:0]    chan_req,
  output logic [N_CH-1:0]    chan_busy,
  output logic               alloc_ok,
  output logic               alloc_none,
  output logic [4:0]         alloc_chan
);
  import dca_pkg::*;
  localparam logic [N_CH-1:0] ONE = N_CH'(1);

  logic [N_CH-1:0] busy_q, rel_mask, busy_eff, gnt_mask, free_vec;
  logic            rel_hit, pick_found, grant;
  logic [CHW-1:0]  pick_idx;

  // release is applied before the search (R6)
  assign rel_hit  = rel_en && ({1'b0, rel_chan} < 6'(N_CH));
  assign rel_mask = rel_hit ? (ONE << rel_chan) : '0;
  assign busy_eff = busy_q & ~rel_mask;
  assign free_vec = ~busy_eff;

  dca_pick #(.N_CH(N_CH)) u_pick (
    .free  (free_vec),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign grant    = alloc_req && pick_found;
  assign gnt_mask = grant ? (ONE << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= '0;
      alloc_ok   <= 1'b0;
      alloc_none <= 1'b0;
      alloc_chan <= '0;
    end else begin
      busy_q     <= busy_eff | gnt_mask;
      alloc_ok   <= grant;
      alloc_none <= alloc_req && !pick_found;
      alloc_chan <= grant ? pick_idx : '0;
    end
  end

  dca_map #(.N_CH(N_CH), .N_LINES(N_LINES)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (grant),
    .wr_line  (alloc_line),
    .wr_chan  (pick_idx),
    .clr_en   (rel_hit),
    .clr_chan (rel_chan),
    .rd_line  (map_rd_line),
    .per_req  (per_req),
    .rd_data  (map_rd_data),
    .chan_req (chan_req)
  );

  assign chan_busy = busy_q;
endmodule

// File: rtl/dca_chk.sv
`timescale 1ns/1ps
module dca_chk #(
  parameter int N_CH = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_ok,
  input logic            alloc_none,
  input logic [4:0]      alloc_chan,
  input logic [N_CH-1:0] chan_busy,
  input logic [N_CH-1:0] rel_mask
);
  localparam logic [N_CH-1:0] ONE = N_CH'(1);

  assert_grant_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (chan_busy & (ONE << alloc_chan)) != '0);

  assert_new_busy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_busy & ~$past(chan_busy)));

  assert_none_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_none |-> (chan_busy == $past(chan_busy)) && !alloc_ok);

  assert_grant_was_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (($past(chan_busy) & ~$past(rel_mask)) & (ONE << alloc_chan)) == '0);

  assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_mask != '0) |=> ((chan_busy & $past(rel_mask)) == '0) ||
                         (alloc_ok && (ONE << alloc_chan) == $past(rel_mask)));
endmodule

bind dma_chan_alloc dca_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/sim_dma_chan_alloc.sv
`timescale 1ns/1ps
module sim_dma_chan_alloc;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0;
  logic [3:0] alloc_line = '0;
  logic rel_en = 1'b0;
  logic [4:0] rel_chan = '0;
  logic [NL-1:0] per_req = '0;
  logic [3:0] map_rd_line = '0;

  logic [7:0]  rd0, rd1;
  logic [31:0] creq0, busy0;
  logic [19:0] creq1, busy1;
  logic ok0, none0, ok1, none1;
  logic [4:0] ch0, ch1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_chan_alloc #(.N_CH(32), .N_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_line(alloc_line),
    .rel_en(rel_en), .rel_chan(rel_chan), .per_req(per_req), .map_rd_line(map_rd_line),
    .map_rd_data(rd0), .chan_req(creq0), .chan_busy(busy0),
    .alloc_ok(ok0), .alloc_none(none0), .alloc_chan(ch0));

  dma_chan_alloc #(.N_CH(20), .N_LINES(NL)) u1 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_line(alloc_line),
    .rel_en(rel_en), .rel_chan(rel_chan), .per_req(per_req), .map_rd_line(map_rd_line),
    .map_rd_data(rd1), .chan_req(creq1), .chan_busy(busy1),
    .alloc_ok(ok1), .alloc_none(none1), .alloc_chan(ch1));

  // reference model: index 0 -> 32 channels, index 1 -> 20 channels
  int  nch [2] = '{32, 20};
  bit  mb [2][32];
  bit  mv [2][NL];
  int  mc [2][NL];
  bit  e_ok [2];
  bit  e_none [2];
  int  e_ch [2];

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 32; i++) mb[k][i] = 0;
      for (int l = 0; l < NL; l++) begin mv[k][l] = 0; mc[k][l] = 0; end
      e_ok[k] = 0; e_none[k] = 0; e_ch[k] = 0;
    end
  endtask

  // predicts the state after the coming clock edge
  task automatic model_step(input int k);
    int n, best, bestkey, key, lim;
    n = nch[k];
    if (rel_en && int'(rel_chan) < n) begin
      mb[k][rel_chan] = 0;
      for (int l = 0; l < NL; l++)
        if (mv[k][l] && mc[k][l] == int'(rel_chan)) begin mv[k][l] = 0; mc[k][l] = 0; end
    end
    e_ok[k] = 0; e_none[k] = 0; e_ch[k] = 0;
    if (alloc_req) begin
      lim = ((n - 1) % 16) / 4;
      best = -1; bestkey = 1000000;
      for (int i = 0; i < n; i++) begin
        key = ((i % 16) / 4) * 100 + i;
        if (!mb[k][i] && ((i % 16) / 4) <= lim && key < bestkey) begin
          bestkey = key; best = i;
        end
      end
      if (best >= 0) begin
        mb[k][best] = 1;
        mv[k][alloc_line] = 1;
        mc[k][alloc_line] = best;
        e_ok[k] = 1; e_ch[k] = best;
      end else e_none[k] = 1;
    end
  endtask

  function automatic longint exp_busy(input int k);
    longint v = 0;
    for (int i = 0; i < nch[k]; i++) if (mb[k][i]) v |= (64'd1 << i);
    return v;
  endfunction

  function automatic longint exp_creq(input int k);
    longint v = 0;
    for (int l = 0; l < NL; l++)
      if (per_req[l] && mv[k][l]) v |= (64'd1 << mc[k][l]);
    return v;
  endfunction

  task automatic compare_all();
    longint eb, ec, em;
    eb = exp_busy(0); ec = exp_creq(0);
    chk(longint'(busy0) == eb, "R3", "u0 busy", longint'(busy0), eb);
    chk(ok0 == e_ok[0], "R3", "u0 ok", ok0, e_ok[0]);
    chk(none0 == e_none[0], "R4", "u0 none", none0, e_none[0]);
    chk(int'(ch0) == e_ch[0], "R2", "u0 chan", ch0, e_ch[0]);
    chk(longint'(creq0) == ec, "R7", "u0 chan_req", longint'(creq0), ec);
    eb = exp_busy(1); ec = exp_creq(1);
    chk(longint'(busy1) == eb, "R9", "u1 busy", longint'(busy1), eb);
    chk(ok1 == e_ok[1], "R9", "u1 ok", ok1, e_ok[1]);
    chk(none1 == e_none[1], "R9", "u1 none", none1, e_none[1]);
    chk(int'(ch1) == e_ch[1], "R9", "u1 chan", ch1, e_ch[1]);
    chk(longint'(creq1) == ec, "R7", "u1 chan_req", longint'(creq1), ec);
    for (int l = 0; l < NL; l++) begin
      map_rd_line = 4'(l);
      #0.1;
      em = mv[0][l] ? (128 + mc[0][l]) : 0;
      chk(longint'(rd0) == em, "R10", "u0 map", rd0, em);
      em = mv[1][l] ? (128 + mc[1][l]) : 0;
      chk(longint'(rd1) == em, "R10", "u1 map", rd1, em);
    end
  endtask

  // we sit at a negedge; apply inputs, predict, advance, compare
  task automatic cyc(input bit a, input int line, input bit r, input int rc, input logic [NL-1:0] pr);
    alloc_req = a; alloc_line = 4'(line); rel_en = r; rel_chan = 5'(rc); per_req = pr;
    model_step(0); model_step(1);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    per_req = '1;
    #0.1;
    // R1 reset state; R8 requests on never-mapped lines route nowhere
    chk(busy0 == 0 && busy1 == 0, "R1", "busy after reset", busy0, 0);
    chk(!ok0 && !none0 && ch0 == 0, "R1", "grant outputs after reset", {ok0, none0, ch0}, 0);
    chk(creq0 == 0 && creq1 == 0, "R8", "chan_req with invalid map", creq0, 0);
    compare_all();

    // fill both instances: 33 allocations
    for (int j = 0; j < 33; j++) begin
      cyc(1, j % NL, 0, 0, '0);
      if (j == 4) chk(ch0 == 16, "R2", "fifth grant in group 0", ch0, 16);
      if (j == 8) begin
        chk(ch0 == 4, "R2", "ninth grant starts group 1", ch0, 4);
        chk(none1 == 1 && ok1 == 0, "R9", "20-channel instance exhausted", none1, 1);
      end
      if (j == 32) chk(none0 == 1 && ok0 == 0, "R4", "32-channel instance exhausted", none0, 1);
    end
    cyc(0, 0, 0, 0, '0);

    // R6 release and allocate together: 17 is freed and granted again
    cyc(1, 3, 1, 17, '0);
    chk(ok0 && ch0 == 17, "R6", "u0 regrant released channel", ch0, 17);
    chk(ok1 && ch1 == 17, "R6", "u1 regrant released channel", ch1, 17);

    // R5 plain release of channel 30; map entry of line 14 held channel 30
    cyc(1, 14, 0, 0, '0);
    cyc(0, 0, 1, 30, '0);
    chk(busy0[30] == 0, "R5", "busy cleared", busy0[30], 0);
    map_rd_line = 4'd14; #0.1;
    chk(rd0 == 8'h00, "R5", "map entry wiped", rd0, 0);
    // R8 request on that now invalid line
    cyc(0, 0, 0, 0, NL'(1) << 14);
    chk(creq0 == 0, "R8", "ignored request", creq0, 0);
    // R5 release out of range on u1 has no effect
    cyc(0, 0, 1, 25, '0);
    chk(busy1 == 20'hF000F, "R5", "u1 out-of-range release", busy1, 20'hF000F);
    // R7 route every line
    cyc(0, 0, 0, 0, '1);

    for (int j = 0; j < 400; j++)
      cyc(($urandom % 2) == 0, $urandom % NL, ($urandom % 5) < 2, $urandom % 32, NL'($urandom));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule